// File: doc/BRIEF.md
# I2C Target Pin Conditioner

This block sits between the raw SCL and SDA pads and an I2C target protocol engine. Both incoming lines pass through a two-flop synchronizer and then through a digital glitch filter. Each filter has its own length setting. A filter ignores any excursion of the line that is no longer than its setting. On the output side the block holds back each new SDA value from the engine until a programmable data-valid delay has run after the filtered SCL falls. It also keeps SCL pulled low for a programmable minimum time whenever the engine asks to stretch the clock.

All three timers count undivided functional-clock cycles. A high-speed-mode flag turns all three timers off, so that the filters, the data-valid delay and the clock hold become plain pass-throughs. The pads are open-drain: an asserted enable pulls the pad low, and a released enable lets it float high. There is no data stream at this block's edge; every pin is a plain control or level signal, so no valid/ready handshake applies.

Top module: `i2c_pin_cond`

## Requirements
- R1: While `rst` is high, at the following clock edge both filtered outputs become 1, `scl_pad_oe` becomes 0, and (outside high-speed mode) `sda_pad_oe` becomes 0.
- R2: With a filter length N of 1 to 15, a pad pulse lasting N cycles or fewer leaves that line's filtered output at its previous level.
- R3: With a filter length N of 1 to 15, a pad level held for longer than N cycles appears on the filtered output N+3 clock edges after the pad changes: 2 edges for the synchronizer and N+1 edges for the filter.
- R4: With a filter length of 0, a pad change reaches the filtered output after exactly 2 clock edges.
- R5: The SCL filter and the SDA filter use separate length settings and do not affect each other.
- R6: With data-valid delay D, `sda_pad_oe` takes the value latched at a filtered SCL fall D+1 clock edges after `scl_filt_o` goes low. `sda_pad_oe` is 1 (pad pulled low) when the latched drive bit is 0, and 0 when the latched bit is 1.
- R7: The engine SDA bit is latched at the edge that detects the filtered SCL fall. Later changes to the engine SDA bit do not reach `sda_pad_oe` before the next fall.
- R8: If `eng_stretch` is high at the edge that detects a filtered SCL fall and the hold setting is H, then `scl_pad_oe` stays 1 for at least H+1 edges after `scl_filt_o` goes low. It drops at exactly that edge if the stretch request has been withdrawn by then.
- R9: `scl_pad_oe` is 1 in every cycle in which `eng_stretch` is 1.
- R10: In high-speed mode the filters have a 2-edge latency whatever their length setting, `sda_pad_oe` equals the inverse of `eng_sda_drive` within the same cycle, and `scl_pad_oe` equals `eng_stretch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_mode | input | 1 | High-speed mode; bypasses all three timers |
| cfg_filt_scl | input | 4 | SCL glitch filter length, 0 disables it |
| cfg_filt_sda | input | 4 | SDA glitch filter length, 0 disables it |
| cfg_dv_delay | input | 6 | Data-valid delay in cycles after the filtered SCL fall |
| cfg_hold | input | 4 | Minimum SCL low hold while stretching |
| scl_pad_i | input | 1 | Raw SCL pad level |
| sda_pad_i | input | 1 | Raw SDA pad level |
| eng_sda_drive | input | 1 | Engine SDA bit, 0 = pull low |
| eng_stretch | input | 1 | Engine clock-stretch request |
| scl_filt_o | output | 1 | Synchronized, filtered SCL |
| sda_filt_o | output | 1 | Synchronized, filtered SDA |
| scl_pad_oe | output | 1 | 1 pulls the SCL pad low |
| sda_pad_oe | output | 1 | 1 pulls the SDA pad low |

## Verification
The filters are driven with pulses one to N cycles long, which must vanish, and with a level held one cycle beyond N, which must pass. This separates an off-by-one in the filter compare from a correct threshold. Both lines are switched in the same cycle under different lengths, which catches a swapped or shared setting. The output side is tried with data-valid delays of zero and non-zero and with an engine bit that flips just after the fall, which separates latch-at-fall from live pass-through. Stretch is tried both withdrawn early, which measures the hold length, and kept on, which shows the request dominates. A high-speed pass confirms that every timer is bypassed.

// File: rtl/i2c_pc_pkg.sv
package i2c_pc_pkg;
  localparam int FILT_W_DEF  = 4;
  localparam int DV_W_DEF    = 6;
  localparam int HOLD_W_DEF  = 4;
  localparam int N_LINES     = 2;
  localparam int LINE_SCL    = 0;
  localparam int LINE_SDA    = 1;
endpackage

// File: rtl/i2c_pc_glitch.sv
module i2c_pc_glitch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hs_mode,
  input  logic [W-1:0] len,
  input  logic         raw,
  output logic         filt
);
  logic         s1_q, s2_q, out_q;
  logic [W-1:0] cnt_q;
  logic         byp;

  assign byp = hs_mode || (len == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      out_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
      if (byp) begin
        out_q <= s2_q;
        cnt_q <= '0;
      end else if (s2_q != out_q) begin
        if (cnt_q >= len) begin
          out_q <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign filt = byp ? s2_q : out_q;

  // R2 / R3: with the filter active, the held level moves only after the run count reached the length
  assert_glitch_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(byp) && (out_q != $past(out_q))) |-> $past(cnt_q >= len));

  // R3: the run counter restarts whenever the synchronized line agrees with the held level
  assert_run_restart_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!byp && (s2_q == out_q))) |-> (cnt_q == '0));
endmodule

// File: rtl/i2c_pc_dvdelay.sv
module i2c_pc_dvdelay #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hs_mode,
  input  logic         scl_fall,
  input  logic [W-1:0] dly,
  input  logic         eng_sda,
  output logic         drive_o
);
  logic [W-1:0] cnt_q;
  logic         pend_q, drive_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pend_q  <= 1'b1;
      drive_q <= 1'b1;
    end else if (hs_mode) begin
      cnt_q   <= '0;
      pend_q  <= eng_sda;
      drive_q <= eng_sda;
    end else if (scl_fall) begin
      pend_q <= eng_sda;
      if (dly == '0) begin
        drive_q <= eng_sda;
        cnt_q   <= '0;
      end else begin
        cnt_q <= dly;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == 1) drive_q <= pend_q;
    end
  end

  assign drive_o = hs_mode ? eng_sda : drive_q;

  // R7: the presented bit changes only at a detected fall or when the delay expires
  assert_dv_latch_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!hs_mode && !scl_fall && (cnt_q != 1)) && !hs_mode) |-> (drive_q == $past(drive_q)));

  // R6: with a zero delay the engine bit present at the fall is presented one edge later
  assert_dv_zero_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!hs_mode && scl_fall && (dly == '0)) |-> (drive_q == $past(eng_sda)));
endmodule

// File: rtl/i2c_pc_hold.sv
module i2c_pc_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hs_mode,
  input  logic         scl_fall,
  input  logic         stretch,
  input  logic [W-1:0] hold,
  output logic         oe_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || hs_mode) begin
      cnt_q <= '0;
    end else if (scl_fall && stretch) begin
      cnt_q <= hold;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign oe_o = stretch || (cnt_q != '0);

  // R8: a stretch seen at the fall keeps SCL low on the following edge when a hold is set
  assert_hold_min_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(!hs_mode && scl_fall && stretch && (hold != '0)) && !hs_mode) |-> oe_o);

  // R9: a pending stretch request always pulls SCL low
  assert_stretch_low_R9: assert property (@(posedge clk) disable iff (rst)
    stretch |-> oe_o);
endmodule

// File: rtl/i2c_pin_cond.sv
module i2c_pin_cond
  import i2c_pc_pkg::*;
#(
  parameter int FILT_W = FILT_W_DEF,
  parameter int DV_W   = DV_W_DEF,
  parameter int HOLD_W = HOLD_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_mode,
  input  logic [FILT_W-1:0] cfg_filt_scl,
  input  logic [FILT_W-1:0] cfg_filt_sda,
  input  logic [DV_W-1:0]   cfg_dv_delay,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic              scl_pad_i,
  input  logic              sda_pad_i,
  input  logic              eng_sda_drive,
  input  logic              eng_stretch,
  output logic              scl_filt_o,
  output logic              sda_filt_o,
  output logic              scl_pad_oe,
  output logic              sda_pad_oe
);
  logic [N_LINES-1:0] line_raw, line_filt;
  logic [FILT_W-1:0]  line_len [N_LINES];
  logic               scl_prev_q, scl_fall, sda_drive;

  assign line_raw[LINE_SCL] = scl_pad_i;
  assign line_raw[LINE_SDA] = sda_pad_i;
  assign line_len[LINE_SCL] = cfg_filt_scl;
  assign line_len[LINE_SDA] = cfg_filt_sda;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    i2c_pc_glitch #(.W(FILT_W)) u_filt (
      .clk     (clk),
      .rst     (rst),
      .hs_mode (hs_mode),
      .len     (line_len[i]),
      .raw     (line_raw[i]),
      .filt    (line_filt[i])
    );
  end

  assign scl_filt_o = line_filt[LINE_SCL];
  assign sda_filt_o = line_filt[LINE_SDA];

  always_ff @(posedge clk) begin
    if (rst) scl_prev_q <= 1'b1;
    else     scl_prev_q <= scl_filt_o;
  end

  assign scl_fall = scl_prev_q && !scl_filt_o;

  i2c_pc_dvdelay #(.W(DV_W)) u_dv (
    .clk     (clk),
    .rst     (rst),
    .hs_mode (hs_mode),
    .scl_fall(scl_fall),
    .dly     (cfg_dv_delay),
    .eng_sda (eng_sda_drive),
    .drive_o (sda_drive)
  );

  i2c_pc_hold #(.W(HOLD_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .hs_mode (hs_mode),
    .scl_fall(scl_fall),
    .stretch (eng_stretch),
    .hold    (cfg_hold),
    .oe_o    (scl_pad_oe)
  );

  assign sda_pad_oe = !sda_drive;

  // R1: reset returns the lines high and releases both pads
  assert_reset_state_R1: assert property (@(posedge clk)
    (rst && !eng_stretch && !hs_mode) |=> (scl_filt_o && sda_filt_o && !scl_pad_oe && !sda_pad_oe));

  // R10: in high-speed mode the pad enables follow the engine directly
  assert_hs_pass_R10: assert property (@(posedge clk) disable iff (rst)
    hs_mode |-> ((sda_pad_oe == !eng_sda_drive) && (scl_pad_oe == eng_stretch)));
endmodule

// File: tb/i2c_pin_cond_bench.sv
`timescale 1ns/1ps
module i2c_pin_cond_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hs_mode = 1'b0;
  logic [3:0] cfg_filt_scl = '0;
  logic [3:0] cfg_filt_sda = '0;
  logic [5:0] cfg_dv_delay = '0;
  logic [3:0] cfg_hold = '0;
  logic       scl_pad_i = 1'b1;
  logic       sda_pad_i = 1'b1;
  logic       eng_sda_drive = 1'b1;
  logic       eng_stretch = 1'b0;
  logic       scl_filt_o, sda_filt_o, scl_pad_oe, sda_pad_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  i2c_pin_cond u_i2c_pin_cond (
    .clk(clk), .rst(rst), .hs_mode(hs_mode),
    .cfg_filt_scl(cfg_filt_scl), .cfg_filt_sda(cfg_filt_sda),
    .cfg_dv_delay(cfg_dv_delay), .cfg_hold(cfg_hold),
    .scl_pad_i(scl_pad_i), .sda_pad_i(sda_pad_i),
    .eng_sda_drive(eng_sda_drive), .eng_stretch(eng_stretch),
    .scl_filt_o(scl_filt_o), .sda_filt_o(sda_filt_o),
    .scl_pad_oe(scl_pad_oe), .sda_pad_oe(sda_pad_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return scl_filt_o;
      1: return sda_filt_o;
      2: return sda_pad_oe;
      default: return scl_pad_oe;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // counts edges until the selected output reaches v (gives up at 60)
  task automatic edges_until(input int sel, input logic v, output int n);
    n = 0;
    while (sig(sel) != v && n < 60) begin
      tick();
      n++;
    end
  endtask

  task automatic settle(input int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  task automatic t_reset();
    chk("R1 scl_filt", scl_filt_o, 1);
    chk("R1 sda_filt", sda_filt_o, 1);
    chk("R1 scl_oe", scl_pad_oe, 0);
    chk("R1 sda_oe", sda_pad_oe, 0);
  endtask

  task automatic t_glitch();
    int n;
    logic moved;
    cfg_filt_sda = 4'd4;
    settle(4);
    for (int p = 1; p <= 4; p++) begin
      moved = 0;
      sda_pad_i = 1'b0;
      for (int i = 0; i < p; i++) begin tick(); if (!sda_filt_o) moved = 1; end
      sda_pad_i = 1'b1;
      for (int i = 0; i < 10; i++) begin tick(); if (!sda_filt_o) moved = 1; end
      chk($sformatf("R2 pulse %0d ignored", p), moved, 0);
    end
    sda_pad_i = 1'b0;
    edges_until(1, 1'b0, n);
    chk("R3 fall latency N=4", n, 7);
    settle(3);
    sda_pad_i = 1'b1;
    edges_until(1, 1'b1, n);
    chk("R3 rise latency N=4", n, 7);
  endtask

  task automatic t_bypass();
    int n;
    cfg_filt_sda = 4'd0;
    settle(3);
    sda_pad_i = 1'b0;
    edges_until(1, 1'b0, n);
    chk("R4 latency N=0", n, 2);
    sda_pad_i = 1'b1;
    settle(4);
  endtask

  task automatic t_independent();
    int ns, nd;
    cfg_filt_scl = 4'd2;
    cfg_filt_sda = 4'd6;
    settle(3);
    ns = -1; nd = -1;
    scl_pad_i = 1'b0;
    sda_pad_i = 1'b0;
    for (int i = 1; i <= 15; i++) begin
      tick();
      if (ns < 0 && !scl_filt_o) ns = i;
      if (nd < 0 && !sda_filt_o) nd = i;
    end
    chk("R5 scl latency N=2", ns, 5);
    chk("R5 sda latency N=6", nd, 9);
    scl_pad_i = 1'b1;
    sda_pad_i = 1'b1;
    cfg_filt_scl = 4'd0;
    cfg_filt_sda = 4'd0;
    settle(12);
  endtask

  task automatic scl_fall_wait();
    int n;
    scl_pad_i = 1'b0;
    edges_until(0, 1'b0, n);
  endtask

  task automatic t_dv_delay();
    int n;
    cfg_dv_delay = 6'd5;
    eng_sda_drive = 1'b0;
    scl_fall_wait();
    edges_until(2, 1'b1, n);
    chk("R6 delay D=5", n, 6);
    scl_pad_i = 1'b1;
    settle(5);
    cfg_dv_delay = 6'd0;
    eng_sda_drive = 1'b1;
    scl_fall_wait();
    edges_until(2, 1'b0, n);
    chk("R6 delay D=0", n, 1);
    scl_pad_i = 1'b1;
    settle(5);
  endtask

  task automatic t_latch();
    int n, first;
    logic back;
    cfg_dv_delay = 6'd3;
    eng_sda_drive = 1'b0;
    scl_fall_wait();
    edges_until(2, 1'b1, n);
    chk("R6 delay D=3", n, 4);
    scl_pad_i = 1'b1;
    settle(5);
    eng_sda_drive = 1'b1;
    scl_fall_wait();
    tick();
    eng_sda_drive = 1'b0;
    first = -1;
    back = 0;
    for (int i = 2; i <= 14; i++) begin
      tick();
      if (first < 0 && !sda_pad_oe) first = i;
      else if (first >= 0 && sda_pad_oe) back = 1;
    end
    chk("R7 latched bit presented at D+1", first, 4);
    chk("R7 later engine change ignored", back, 0);
    scl_pad_i = 1'b1;
    settle(5);
  endtask

  task automatic t_hold();
    int n;
    logic low_all;
    cfg_hold = 4'd4;
    eng_stretch = 1'b1;
    scl_fall_wait();
    tick();
    n = 1;
    eng_stretch = 1'b0;
    while (scl_pad_oe && n < 40) begin tick(); n++; end
    chk("R8 hold release H=4", n, 5);
    scl_pad_i = 1'b1;
    settle(5);
    eng_stretch = 1'b1;
    scl_fall_wait();
    low_all = 1;
    for (int i = 0; i < 20; i++) begin tick(); if (!scl_pad_oe) low_all = 0; end
    chk("R9 stretch keeps SCL low", low_all, 1);
    eng_stretch = 1'b0;
    tick();
    chk("R9 release after stretch and hold", scl_pad_oe, 0);
    scl_pad_i = 1'b1;
    cfg_hold = 4'd0;
    settle(5);
  endtask

  task automatic t_hs();
    int n;
    hs_mode = 1'b1;
    cfg_filt_scl = 4'd9;
    cfg_filt_sda = 4'd9;
    cfg_dv_delay = 6'd20;
    cfg_hold = 4'd10;
    settle(3);
    scl_pad_i = 1'b0;
    edges_until(0, 1'b0, n);
    chk("R10 hs filter latency", n, 2);
    eng_sda_drive = 1'b0;
    #1;
    chk("R10 hs sda pass", sda_pad_oe, 1);
    eng_sda_drive = 1'b1;
    #1;
    chk("R10 hs sda release", sda_pad_oe, 0);
    eng_stretch = 1'b1;
    #1;
    chk("R10 hs stretch pass", scl_pad_oe, 1);
    eng_stretch = 1'b0;
    tick();
    chk("R10 hs no hold", scl_pad_oe, 0);
    scl_pad_i = 1'b1;
    settle(4);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_glitch();
    t_bypass();
    t_independent();
    t_dv_delay();
    t_latch();
    t_hold();
    t_hs();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule